// File: doc/BRIEF.md
# Programmable Interval Timer Channel

One 16-bit counting channel of an interval timer. A mode write picks one of six waveforms: terminal-count interrupt, retriggerable one-shot, rate generator, square wave, software strobe and hardware strobe. A separate count load then starts the channel. Counting advances only on cycles where the clock-enable input `tick_i` is high. The `gate_i` input behaves according to the mode. In some modes it pauses counting. In the others a rising edge restarts the count from the loaded value. A neighbouring decoder block handles register decoding and host access. This block sees only a mode strobe, a load strobe with its 16-bit value, the gate and the tick.

The channel reports two results. `out_o` is the waveform. `count_o` is the value a host would read as the current count. Both come straight from registers, so they change only at a clock edge, never combinationally from an input.

Top module: `pit_channel`

## Requirements
- R1: After reset the channel is unprogrammed: `out_o` is 0 and `count_o` is 0. Load strobes have no visible effect until a mode has been written.
- R2: A mode write (`mode_wr_i`) stores the 3-bit code from `mode_i`: 0 terminal count, 1 one-shot, 2 rate, 3 square, 4 software strobe, 5 hardware strobe. Codes 6 and 7 act as 2 and 3. The write also leaves the channel idle, with `out_o` 0 and `count_o` 0, until a load takes effect.
- R3: A value strobed by `load_i` takes effect at the first clock in a later cycle where `tick_i` is high. In that cycle the elapsed count restarts at 0 and `count_o` shows the loaded value. A loaded value of 0 means a count of 65536.
- R4: Mode 0: `out_o` is low after the load and goes high when the counted ticks reach the loaded count N. It then stays high.
- R5: Mode 1: `out_o` is low while the counted ticks are below N and high afterwards.
- R6: Mode 2: `out_o` is high for one tick whenever the counted ticks are a nonzero multiple of N. `count_o` is N minus (ticks mod N).
- R7: Mode 3: `out_o` is high for the first (N+1)/2 ticks of each N-tick period and low for the rest. `count_o` is N minus ((2*ticks) mod N), so it steps by two per tick.
- R8: Modes 4 and 5: `out_o` is high only while the counted ticks equal N exactly. There is no reload.
- R9: In modes 0 and 4 a low `gate_i` stops counting. In modes 1, 2, 3 and 5 the gate level is ignored, but a rising edge restarts the count at 0 at that clock, whether or not a tick is present. A mode write takes priority over a load, a load over a restart, and a restart over a tick.
- R10: In modes 0, 1, 4 and 5, `count_o` is (N - ticks) mod 65536, so it wraps past terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count clock enable |
| gate_i | input | 1 | Gate level |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 3 | Mode code |
| load_i | input | 1 | Count load strobe |
| load_val_i | input | 16 | Count value to load |
| count_o | output | 16 | Current count |
| out_o | output | 1 | Timer output waveform |

## Verification
Each event reaches the outputs at a fixed clock. A mode write, a gate restart or a tick shows on `out_o` and `count_o` one clock after the edge that samples it. A load strobe shows one clock after the first later tick edge, so it can arrive at least two clocks after the strobe. The bench drives inputs just after the falling edge. It moves an elapsed-tick reference model on every rising edge and compares both outputs at every falling edge, so each result is checked in the cycle it first becomes due. Gaps between ticks are included to expose the delay of a staged load.

// File: rtl/pitc_pkg.sv
package pitc_pkg;

  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } pit_mode_e;

  // Codes 6 and 7 drop bit 2 and land on rate / square.
  function automatic pit_mode_e fold_mode(input logic [2:0] raw);
    if (raw[2] && raw[1]) return pit_mode_e'({1'b0, raw[1:0]});
    return pit_mode_e'(raw);
  endfunction

  function automatic logic is_retrig(input pit_mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTB);
  endfunction

  function automatic logic is_gated(input pit_mode_e m);
    return (m == M_TERM) || (m == M_SWSTB);
  endfunction

  function automatic logic is_periodic(input pit_mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

endpackage

// File: rtl/pitc_stage.sv
module pitc_stage #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             mode_wr_i,
  input  logic             prog_i,
  output logic             load_fire_o,
  output logic             gate_rise_o,
  output logic [CNT_W-1:0] pend_val_o
);

  logic             gate_q;
  logic             pend_v;
  logic [CNT_W-1:0] pend_q;

  assign load_fire_o = tick_i & pend_v & prog_i & ~mode_wr_i;
  assign gate_rise_o = gate_i & ~gate_q;
  assign pend_val_o  = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      pend_v <= 1'b0;
      pend_q <= '0;
    end else begin
      gate_q <= gate_i;
      if (load_i) begin
        pend_q <= load_val_i;
        pend_v <= 1'b1;
      end else if (load_fire_o) begin
        pend_v <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pitc_core.sv
module pitc_core
  import pitc_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int EW   = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             mode_wr_i,
  input  logic [2:0]       mode_i,
  input  logic             load_fire_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             gate_rise_i,
  output logic             restart_o,
  output logic             count_en_o,
  output logic             prog_o,
  output logic             active_o,
  output pit_mode_e        mode_o,
  output logic [EW-1:0]    n_o,
  output logic [EW-1:0]    ph_o,
  output logic             term_o,
  output logic             hit_o,
  output logic             started_o
);

  localparam logic [EW-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

  pit_mode_e     mode_q;
  logic          prog_q, active_q, term_q, hit_q, started_q;
  logic [EW-1:0] n_q, ph_q, ph_inc, ph_step;
  logic          reach;

  assign restart_o  = active_q & gate_rise_i & is_retrig(mode_q) & ~load_fire_i & ~mode_wr_i;
  assign count_en_o = active_q & tick_i & (gate_i | ~is_gated(mode_q))
                      & ~restart_o & ~load_fire_i & ~mode_wr_i;

  assign ph_inc  = ph_q + 1'b1;
  assign reach   = (ph_inc == n_q);
  assign ph_step = is_periodic(mode_q) ? (reach ? '0 : ph_inc)
                                       : {1'b0, ph_inc[CNT_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= M_TERM;
      prog_q    <= 1'b0;
      active_q  <= 1'b0;
      n_q       <= '0;
      ph_q      <= '0;
      term_q    <= 1'b0;
      hit_q     <= 1'b0;
      started_q <= 1'b0;
    end else if (mode_wr_i) begin
      mode_q   <= fold_mode(mode_i);
      prog_q   <= 1'b1;
      active_q <= 1'b0;
    end else if (load_fire_i || restart_o) begin
      if (load_fire_i) begin
        n_q      <= (load_val_i == '0) ? FULL : {1'b0, load_val_i};
        active_q <= 1'b1;
      end
      ph_q      <= '0;
      term_q    <= 1'b0;
      hit_q     <= 1'b0;
      started_q <= 1'b0;
    end else if (count_en_o) begin
      ph_q      <= ph_step;
      term_q    <= term_q | reach;
      hit_q     <= reach & ~term_q;
      started_q <= 1'b1;
    end
  end

  assign prog_o    = prog_q;
  assign active_o  = active_q;
  assign mode_o    = mode_q;
  assign n_o       = n_q;
  assign ph_o      = ph_q;
  assign term_o    = term_q;
  assign hit_o     = hit_q;
  assign started_o = started_q;

endmodule

// File: rtl/pitc_view.sv
module pitc_view
  import pitc_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int EW   = CNT_W + 1
) (
  input  logic          active_i,
  input  pit_mode_e     mode_i,
  input  logic [EW-1:0] n_i,
  input  logic [EW-1:0] ph_i,
  input  logic          term_i,
  input  logic          hit_i,
  input  logic          started_i,
  output logic [CNT_W-1:0] count_o,
  output logic          out_o
);

  function automatic logic [EW-1:0] half_up(input logic [EW-1:0] n);
    logic [EW:0] s;
    s = {1'b0, n} + 1'b1;
    return s[EW:1];
  endfunction

  // (2*ph) mod n, valid because ph < n
  function automatic logic [EW-1:0] dbl_mod(input logic [EW-1:0] ph, input logic [EW-1:0] n);
    logic [EW:0] t, r;
    t = {ph, 1'b0};
    r = (t >= {1'b0, n}) ? (t - {1'b0, n}) : t;
    return r[EW-1:0];
  endfunction

  logic [EW-1:0] used_ph, remain;

  assign used_ph = (mode_i == M_SQUARE) ? dbl_mod(ph_i, n_i) : ph_i;
  assign remain  = n_i - used_ph;
  assign count_o = active_i ? remain[CNT_W-1:0] : '0;

  always_comb begin
    out_o = 1'b0;
    if (active_i) begin
      unique case (mode_i)
        M_TERM, M_ONESHOT: out_o = term_i;
        M_RATE:            out_o = started_i && (ph_i == '0);
        M_SQUARE:          out_o = (ph_i < half_up(n_i));
        default:           out_o = hit_i;
      endcase
    end
  end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pitc_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int EW   = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             mode_wr_i,
  input  logic [2:0]       mode_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);

  logic             load_fire, gate_rise, restart, count_en, prog, active;
  logic             term, hit, started;
  logic [CNT_W-1:0] pend_val;
  logic [EW-1:0]    n_val, ph_val;
  pit_mode_e        mode_q;

  pitc_stage #(.CNT_W(CNT_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gate_i(gate_i),
    .load_i(load_i), .load_val_i(load_val_i), .mode_wr_i(mode_wr_i),
    .prog_i(prog), .load_fire_o(load_fire), .gate_rise_o(gate_rise),
    .pend_val_o(pend_val)
  );

  pitc_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gate_i(gate_i),
    .mode_wr_i(mode_wr_i), .mode_i(mode_i), .load_fire_i(load_fire),
    .load_val_i(pend_val), .gate_rise_i(gate_rise), .restart_o(restart),
    .count_en_o(count_en), .prog_o(prog), .active_o(active), .mode_o(mode_q),
    .n_o(n_val), .ph_o(ph_val), .term_o(term), .hit_o(hit), .started_o(started)
  );

  pitc_view #(.CNT_W(CNT_W)) u_view (
    .active_i(active), .mode_i(mode_q), .n_i(n_val), .ph_i(ph_val),
    .term_i(term), .hit_i(hit), .started_i(started),
    .count_o(count_o), .out_o(out_o)
  );

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pitc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_wr_i,
  input logic             gate_i,
  input logic [CNT_W-1:0] count_o,
  input logic             out_o,
  input logic             load_fire,
  input logic             restart,
  input logic             count_en,
  input logic             prog,
  input logic             active,
  input pit_mode_e        mode_q,
  input logic [CNT_W-1:0] pend_val
);

  AST_UNPROG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !prog |-> (!out_o && count_o == '0)); // R1

  AST_IDLE_AFTER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_i |=> (!out_o && count_o == '0)); // R2

  AST_LOAD_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> (count_o == $past(pend_val))); // R3

  AST_RATE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RATE && out_o && count_en && count_o != 1) |=> !out_o); // R6

  AST_STROBE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_SWSTB || mode_q == M_HWSTB) && out_o && count_en) |=> !out_o); // R8

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (mode_q == M_TERM || mode_q == M_SWSTB) && !gate_i && !load_fire && !mode_wr_i)
      |=> ($stable(count_o) && $stable(out_o))); // R9

  AST_RETRIG_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (out_o == (mode_q == M_SQUARE))); // R9

endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr_i), .gate_i(gate_i),
  .count_o(count_o), .out_o(out_o), .load_fire(load_fire), .restart(restart),
  .count_en(count_en), .prog(prog), .active(active), .mode_q(mode_q),
  .pend_val(pend_val)
);

// File: tb/pit_channel_tb.sv
module pit_channel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        gate_i = 1'b1;
  logic        mode_wr_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic        load_i = 1'b0;
  logic [15:0] load_val_i = 16'd0;
  logic [15:0] count_o;
  logic        out_o;

  always #4 clk = ~clk;

  pit_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gate_i(gate_i),
    .mode_wr_i(mode_wr_i), .mode_i(mode_i), .load_i(load_i),
    .load_val_i(load_val_i), .count_o(count_o), .out_o(out_o)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // Reference model: elapsed ticks since start of count
  bit m_prog, m_active, m_pendv, m_gprev;
  int m_mode, m_n, m_d, m_pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prog = 0; m_active = 0; m_pendv = 0; m_gprev = 0;
      m_mode = 0; m_n = 0; m_d = 0; m_pend = 0;
    end else begin
      bit rise, fire, retrig, paused;
      rise   = gate_i && !m_gprev;
      fire   = tick_i && m_pendv && m_prog && !mode_wr_i;
      retrig = (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5);
      paused = (m_mode == 0 || m_mode == 4) && !gate_i;
      if (mode_wr_i) begin
        m_mode = (int'(mode_i) > 5) ? int'(mode_i) - 4 : int'(mode_i);
        m_prog = 1; m_active = 0;
      end else if (fire) begin
        m_n = (m_pend == 0) ? 65536 : m_pend;
        m_d = 0; m_active = 1;
      end else if (m_active && rise && retrig) begin
        m_d = 0;
      end else if (m_active && tick_i && !paused) begin
        m_d = m_d + 1;
      end
      if (load_i) begin m_pend = int'(load_val_i); m_pendv = 1; end
      else if (fire) m_pendv = 0;
      m_gprev = gate_i;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_out;
      int exp_cnt;
      exp_out = 0; exp_cnt = 0;
      if (m_active) begin
        case (m_mode)
          0, 1:    begin exp_out = (m_d >= m_n);   exp_cnt = m_n - m_d; end
          2:       begin exp_out = (m_d % m_n == 0) && (m_d != 0); exp_cnt = m_n - (m_d % m_n); end
          3:       begin exp_out = (m_d % m_n) < ((m_n + 1) / 2); exp_cnt = m_n - ((2 * m_d) % m_n); end
          default: begin exp_out = (m_d == m_n);   exp_cnt = m_n - m_d; end
        endcase
      end
      checks += 2;
      if (out_o !== exp_out) begin
        errors++;
        $display("FAIL %s out_o: got %0b expected %0b (ticks %0d)", cur_req, out_o, exp_out, m_d);
      end
      if (count_o !== exp_cnt[15:0]) begin
        errors++;
        $display("FAIL %s count_o: got %0d expected %0d (ticks %0d)", cur_req, count_o, exp_cnt[15:0], m_d);
      end
    end
  end

  task automatic clk1();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n, input int div);
    for (int i = 0; i < n; i++) begin
      tick_i = ((i % div) == div - 1);
      clk1();
    end
    tick_i = 1'b0;
  endtask

  task automatic set_mode(input int m);
    mode_i = 3'(m); mode_wr_i = 1'b1;
    clk1();
    mode_wr_i = 1'b0;
  endtask

  task automatic load(input int v);
    load_val_i = 16'(v); load_i = 1'b1;
    clk1();
    load_i = 1'b0;
  endtask

  task automatic gate_to(input bit g);
    gate_i = g;
    clk1();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  int cyc_n = 0;
  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 199000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc_n);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) clk1();
    rst_n = 1'b1;
    // R1: reset state, loads ignored before any mode write
    cur_req = "R1";
    clk1();
    load(5);
    run(8, 1);
    // R2: codes 7 and 6 fold to square and rate
    cur_req = "R2";
    set_mode(7);
    run(3, 1);
    load(6);
    run(14, 1);
    set_mode(6);
    run(2, 1);
    load(4);
    run(10, 1);
    // R3: staged load with sparse ticks, then zero load = 65536
    cur_req = "R3";
    set_mode(0);
    load(9);
    run(30, 3);
    load(0);
    run(65540, 1);
    // R4: terminal count
    cur_req = "R4";
    load(5);
    run(9, 1);
    run(8, 2);
    // R10: wrap past terminal count
    cur_req = "R10";
    load(3);
    run(10, 1);
    // R5: one-shot with retrigger
    cur_req = "R5";
    set_mode(1);
    load(4);
    run(7, 1);
    gate_to(0);
    gate_to(1);
    run(2, 1);
    gate_to(0);
    tick_i = 1'b1; gate_i = 1'b1; clk1(); tick_i = 1'b0;
    run(6, 1);
    // R6: rate generator
    cur_req = "R6";
    set_mode(2);
    load(3);
    run(12, 1);
    load(1);
    run(5, 1);
    // R7: square wave odd and even
    cur_req = "R7";
    set_mode(3);
    load(5);
    run(16, 1);
    load(6);
    run(15, 2);
    // R8: software and hardware strobes
    cur_req = "R8";
    set_mode(4);
    load(3);
    run(8, 1);
    set_mode(5);
    load(2);
    run(5, 1);
    gate_to(0);
    gate_to(1);
    run(5, 1);
    // R9: gate pause in modes 0 and 4, restart in rate/square
    cur_req = "R9";
    set_mode(0);
    load(6);
    run(3, 1);
    gate_i = 1'b0;
    run(5, 1);
    gate_i = 1'b1;
    run(6, 1);
    set_mode(4);
    load(2);
    run(3, 1);
    gate_i = 1'b0;
    run(4, 1);
    gate_i = 1'b1;
    run(3, 1);
    set_mode(3);
    load(4);
    run(5, 1);
    gate_to(0);
    gate_to(1);
    run(6, 1);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule